// File: doc/BRIEF.md
# BCD to Seven-Segment Decoder

This block turns one binary-coded decimal digit into the seven drive lines of a single numeric display position. A four-bit digit code enters, and seven segment lines leave. Together they light the strokes of the matching numeral. An active-low blanking input darkens the whole position whatever the digit code holds. The decoder has no clock, so its outputs follow its inputs after the gate delay alone.

A parameter adapts the outputs to the wiring of the display. With `ACTIVE_LOW` at 0, a segment is lit by a 1, which suits a display with shared cathodes. With `ACTIVE_LOW` at 1, a segment is lit by a 0, which suits a display with shared anodes. The inversion also covers the dark state, so a blanked or invalid digit stays unlit for either kind of display. The six codes above nine carry no numeral, and the block shows them as a dark position.

Top module: `seg7_digit_decoder`

## Requirements
- R1: When `blank_n` is 0, every segment is dark: `seg_o` is 7'b0000000 with `ACTIVE_LOW`=0 and 7'b1111111 with `ACTIVE_LOW`=1, for every digit code.
- R2: With `blank_n`=1 and `ACTIVE_LOW`=0, digit codes 0 to 4 give `seg_o` = 1111110, 0110000, 1101101, 1111001, 0110011.
- R3: With `blank_n`=1 and `ACTIVE_LOW`=0, digit codes 5 to 9 give `seg_o` = 1011011, 1011111, 1110000, 1111111, 1110011, so the 6 carries its top bar and the 9 has no bottom bar.
- R4: Digit codes 10 to 15 (binary 1010 to 1111) leave every segment dark, whatever the value of `blank_n`.
- R5: `ACTIVE_LOW`=1 gives the bitwise inverse of the `ACTIVE_LOW`=0 output for all 32 combinations of `blank_n` and digit code.
- R6: The bit order of `seg_o` is fixed. Bit 6 is the top bar a. Bits 5 to 1 go clockwise as b (upper right), c (lower right), d (bottom), e (lower left) and f (upper left). Bit 0 is the middle bar g.
- R7: The output depends only on the present inputs. A given `blank_n` and digit code always yield the same `seg_o`, with no memory of earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit_i | input | 4 | BCD digit code, bit 3 most significant |
| blank_n | input | 1 | 0 darkens every segment |
| seg_o | output | 7 | Segment drives, bit 6 = a down to bit 0 = g |

## Verification
A wrong glyph entry shows at once as a bad `seg_o` value for exactly one digit code with `blank_n` high. Only a sweep over every code can expose it, so the bench walks all 32 input combinations. A fault in the blanking or invalid-code path shows as lit segments while `blank_n` is low or the code is above nine. A polarity fault shows as a dark state that is not all ones or all zeros. The block has no state, so a fault appears in the same input setting that exposes it and never spreads to later inputs.

// File: rtl/seg7_pkg.sv
// Package seg7_pkg
// Holds the shared sizes and the segment vector type for the digit decoder.
// Assumes seven segments ordered a (MSB) down to g (LSB).
package seg7_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_N   = 7;
    localparam int MAX_DEC = 9;

    typedef logic [SEG_N-1:0] seg_t;

    localparam seg_t SEG_NONE = '0;
endpackage

// File: rtl/bcd_glyph_rom.sv
// Module bcd_glyph_rom
// Maps a digit code to its active-high stroke pattern (a..g, MSB first).
// Assumes codes above MAX_DEC carry no numeral; they map to all strokes off.
module bcd_glyph_rom
    import seg7_pkg::*;
(
    input  logic [DIGIT_W-1:0] code_i,
    output seg_t               glyph_o
);
    // Select the stroke pattern for the present code.
    always_comb begin
        unique case (code_i)
            4'd0:    glyph_o = 7'b1111110;
            4'd1:    glyph_o = 7'b0110000;
            4'd2:    glyph_o = 7'b1101101;
            4'd3:    glyph_o = 7'b1111001;
            4'd4:    glyph_o = 7'b0110011;
            4'd5:    glyph_o = 7'b1011011;
            4'd6:    glyph_o = 7'b1011111;
            4'd7:    glyph_o = 7'b1110000;
            4'd8:    glyph_o = 7'b1111111;
            4'd9:    glyph_o = 7'b1110011;
            default: glyph_o = SEG_NONE;
        endcase
    end
endmodule

// File: rtl/seg_blank_gate.sv
// Module seg_blank_gate
// Forces every stroke off while the active-low blank input is low.
// Assumes active-high strokes on both sides.
module seg_blank_gate
    import seg7_pkg::*;
(
    input  seg_t glyph_i,
    input  logic blank_n,
    output seg_t gated_o
);
    // Pass the glyph through only while the position is not blanked.
    always_comb begin
        gated_o = blank_n ? glyph_i : SEG_NONE;
    end
endmodule

// File: rtl/seg_polarity.sv
// Module seg_polarity
// Converts active-high strokes to the drive level of the attached display.
// Assumes INVERT=1 for displays whose segments light on logic 0.
module seg_polarity
    import seg7_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  seg_t lit_i,
    output seg_t drive_o
);
    // One driver per segment, with the variant chosen by the parameter.
    for (genvar s = 0; s < SEG_N; s++) begin : g_seg
        if (INVERT) begin : g_inv
            assign drive_o[s] = ~lit_i[s];
        end else begin : g_pass
            assign drive_o[s] = lit_i[s];
        end
    end
endmodule

// File: rtl/seg7_digit_decoder.sv
// Module seg7_digit_decoder
// Top of the single-digit decoder. A digit code and an active-low blank
// go in, seven segment drives (a at bit 6 down to g at bit 0) come out.
// Purely combinational. ACTIVE_LOW selects the output polarity.
module seg7_digit_decoder
    import seg7_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic [3:0] digit_i,
    input  logic       blank_n,
    output logic [6:0] seg_o
);
    seg_t glyph;
    seg_t gated;

    bcd_glyph_rom u_rom (
        .code_i  (digit_i),
        .glyph_o (glyph)
    );

    seg_blank_gate u_gate (
        .glyph_i (glyph),
        .blank_n (blank_n),
        .gated_o (gated)
    );

    seg_polarity #(.INVERT(ACTIVE_LOW)) u_pol (
        .lit_i   (gated),
        .drive_o (seg_o)
    );
endmodule

// File: rtl/seg7_digit_decoder_chk.sv
// Module seg7_digit_decoder_chk
// Port-level checks on the decoder, bound to every instance of it.
// Assumes the checked signals settle within one delta.
module seg7_digit_decoder_chk #(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input logic [3:0] digit_i,
    input logic       blank_n,
    input logic [6:0] seg_o,
    input logic [6:0] gated
);
    localparam logic [6:0] DARK = ACTIVE_LOW ? 7'h7F : 7'h00;

    // Active-high view of the output, recovered from the drive levels.
    logic [6:0] lit;
    assign lit = ACTIVE_LOW ? ~seg_o : seg_o;

    // Relate the ports to one another whenever an input or output moves.
    always_comb begin
        if (!$isunknown({digit_i, blank_n, seg_o})) begin
            a_r1_blank_dark: assert (blank_n || seg_o == DARK)
                else $error("R1 blanked digit not dark");
            a_r4_invalid_dark: assert (digit_i <= 4'd9 || seg_o == DARK)
                else $error("R4 invalid code lit");
            a_r2_valid_lit: assert (!(blank_n && digit_i <= 4'd9) || $countones(lit) >= 2)
                else $error("R2 numeral has too few strokes");
            a_r3_eight_full: assert (!(blank_n && digit_i == 4'd8) || lit == 7'h7F)
                else $error("R3 eight not fully lit");
            a_r5_polarity: assert (lit == gated)
                else $error("R5 polarity stage mismatch");
        end
    end
endmodule

bind seg7_digit_decoder seg7_digit_decoder_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .digit_i (digit_i),
    .blank_n (blank_n),
    .seg_o   (seg_o),
    .gated   (gated)
);

// File: tb/tb_seg7_digit_decoder.sv
// Bench for seg7_digit_decoder: a vector table walked by one loop, then
// directed tests. Instance dut uses ACTIVE_LOW=0, dut_ca uses ACTIVE_LOW=1.
module tb_seg7_digit_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] digit;
    logic       blank_n;
    logic [6:0] seg_cc;
    logic [6:0] seg_ca;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    // 100 MHz clock.
    always #5 clk = ~clk;

    seg7_digit_decoder #(.ACTIVE_LOW(1'b0)) dut (
        .digit_i (digit), .blank_n (blank_n), .seg_o (seg_cc));
    seg7_digit_decoder #(.ACTIVE_LOW(1'b1)) dut_ca (
        .digit_i (digit), .blank_n (blank_n), .seg_o (seg_ca));

    // Vectors {code, expected active-high strokes a..g}, the 16 codes.
    localparam logic [10:0] VEC [16] = '{
        {4'd0,  7'b1111110}, {4'd1,  7'b0110000}, {4'd2,  7'b1101101},
        {4'd3,  7'b1111001}, {4'd4,  7'b0110011}, {4'd5,  7'b1011011},
        {4'd6,  7'b1011111}, {4'd7,  7'b1110000}, {4'd8,  7'b1111111},
        {4'd9,  7'b1110011}, {4'd10, 7'b0000000}, {4'd11, 7'b0000000},
        {4'd12, 7'b0000000}, {4'd13, 7'b0000000}, {4'd14, 7'b0000000},
        {4'd15, 7'b0000000}};

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s digit=%0d blank_n=%0b actual=%b expected=%b",
                     req, digit, blank_n, act, exp);
        end
    endtask

    // Drive an input pair on a falling edge and let it settle.
    task automatic apply(input logic [3:0] d, input logic b);
        @(negedge clk);
        digit = d;
        blank_n = b;
        #1;
    endtask

    initial begin
        digit = 4'd8;
        blank_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state: blanked from the start (R1).
        check("R1", seg_cc, 7'h00);
        check("R1", seg_ca, 7'h7F);

        // Table walk: each code lit and blanked, both polarities.
        for (int i = 0; i < 16; i++) begin
            logic [6:0] e;
            e = VEC[i][6:0];
            apply(VEC[i][10:7], 1'b1);
            if (i < 5)       check("R2", seg_cc, e);
            else if (i < 10) check("R3", seg_cc, e);
            else             check("R4", seg_cc, e);
            check("R5", seg_ca, ~e);
            apply(VEC[i][10:7], 1'b0);
            check("R1", seg_cc, 7'h00);
            check("R5", seg_ca, 7'h7F);
        end

        // Glyph details named by bit: 6 has a (bit 6), 9 lacks d (bit 3).
        apply(4'd6, 1'b1);
        check("R6", {6'b0, seg_cc[6]}, 7'd1);
        apply(4'd9, 1'b1);
        check("R6", {6'b0, seg_cc[3]}, 7'd0);
        // Middle bar g at bit 0 on 0 and 1 dark, on 2 lit.
        apply(4'd0, 1'b1);
        check("R6", {6'b0, seg_cc[0]}, 7'd0);
        apply(4'd2, 1'b1);
        check("R6", {6'b0, seg_cc[0]}, 7'd1);

        // Invalid code while blanked and while enabled (R4).
        apply(4'd15, 1'b0);
        check("R4", seg_ca, 7'h7F);
        apply(4'd10, 1'b1);
        check("R4", seg_ca, 7'h7F);

        // No memory: same inputs after different history (R7).
        apply(4'd8, 1'b1);
        apply(4'd3, 1'b1);
        check("R7", seg_cc, 7'b1111001);
        apply(4'd12, 1'b0);
        apply(4'd3, 1'b1);
        check("R7", seg_cc, 7'b1111001);
        check("R7", seg_ca, 7'b0000110);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule